// File: doc/BRIEF.md
# Flag-Driven Counter Sequence Controller

This block pairs a small up-counter and two single-bit flags with a three-state control unit. After a start pulse it clears the counter and the completion flag, then counts up by one on every clock. While it counts, the third counter bit is copied into the tracking flag. Counting ends once the two top counter bits are both set. A closing state then raises the completion flag and hands control back to idle.

The states and their codes are idle `ST_IDLE` (00), run `ST_RUN` (01) and done `ST_DONE` (11). Code 10 is a spare: it is never entered in normal operation and falls back to idle on the next clock. The transitions are:

- idle-hold: idle to idle when start is low.
- launch: idle to run when start is high.
- count-on: run to run while the top two counter bits are not both 1.
- halt: run to done when they are both 1.
- close: done to idle, always.

The next state is chosen by one multiplexer per state-code bit, indexed by the present state. A decoder turns the registered code into one-hot state indicators. Every decision taken in run uses the counter value held before that clock's increment.

Top module: `flagseq_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves the block in idle with cnt = 0, flag_e = 0 and flag_f = 0.
- R2: In idle with start low, state, cnt, flag_e and flag_f all keep their values across the clock.
- R3: In idle with start high, the next clock gives cnt = 0, flag_f = 0 and the run state, and flag_e is unchanged.
- R4: In run, cnt rises by exactly one on every clock.
- R5: In run, flag_e after the clock equals bit 2 of cnt before that clock (bits numbered 0 to 3, bit 3 the MSB).
- R6: In run, the block moves to done when bits 3 and 2 of the pre-increment cnt are both 1, and otherwise stays in run. From a launch, this gives 13 run cycles (cnt 0 through 12), after which cnt = 13 in done.
- R7: In done, the next clock sets flag_f to 1, keeps cnt and flag_e, and returns to idle.
- R8: Exactly one of st_idle, st_run and st_done is high in every cycle, and it matches the current state.
- R9: A high start while in run or done has no effect on state, cnt or the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch request, acted on only in idle |
| cnt | output | CNT_W (4) | Counter value |
| flag_e | output | 1 | Tracking flag, loaded from counter bit 2 during run |
| flag_f | output | 1 | Completion flag, set in done and cleared on launch |
| st_idle | output | 1 | One-hot indicator for idle |
| st_run | output | 1 | One-hot indicator for run |
| st_done | output | 1 | One-hot indicator for done |

## Verification
Three things happen on the same edge: the halting decision, the last increment and a set of the tracking flag. When the pre-increment count is 12, that one edge must give cnt = 13, flag_e = 1 and the done indicator together. The bench reaches this edge with complete sequences from a launch, and checks all outputs after every edge. A second overlap is a start held high across done: the request must be ignored in done, then restart the count in the very next idle cycle. The bench judges this by clearing flag_f one cycle after it was set.

// File: rtl/flagseq_pkg.sv
package flagseq_pkg;

    // State codes; ST_SPARE is never entered in normal operation
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RUN   = 2'b01,
        ST_SPARE = 2'b10,
        ST_DONE  = 2'b11
    } fs_state_e;

    // Commands from the control unit to the datapath
    typedef struct packed {
        logic clr;    // clear counter and completion flag
        logic inc;    // advance counter
        logic e_ld;   // load tracking flag from counter
        logic f_set;  // raise completion flag
    } fs_cmd_t;

    localparam int FS_NUM_LIVE = 3;

endpackage

// File: rtl/flagseq_next.sv
module flagseq_next
    import flagseq_pkg::*;
(
    input  fs_state_e cur,
    input  logic      start,
    input  logic      bit_hi,
    input  logic      bit_lo,
    output fs_state_e nxt
);

    logic halt;
    logic [3:0] mux_hi;
    logic [3:0] mux_lo;

    assign halt = bit_hi & bit_lo;

    // One multiplexer per state-code bit, data inputs indexed by present code
    always_comb begin
        mux_hi = {1'b0,    // 11 done  -> idle
                  1'b0,    // 10 spare -> idle
                  halt,    // 01 run   -> done when halting
                  1'b0};   // 00 idle
        mux_lo = {1'b0,    // 11 done
                  1'b0,    // 10 spare
                  1'b1,    // 01 run keeps low bit set (run or done)
                  start};  // 00 idle -> run on start
        nxt = fs_state_e'({mux_hi[cur], mux_lo[cur]});
    end

endmodule

// File: rtl/flagseq_dec.sv
module flagseq_dec
    import flagseq_pkg::*;
(
    input  fs_state_e cur,
    output logic      st_idle,
    output logic      st_run,
    output logic      st_done
);

    localparam fs_state_e LIVE [FS_NUM_LIVE] = '{ST_IDLE, ST_RUN, ST_DONE};

    logic [FS_NUM_LIVE-1:0] line;

    for (genvar g = 0; g < FS_NUM_LIVE; g++) begin : g_line
        assign line[g] = (cur == LIVE[g]);
    end

    assign st_idle = line[0];
    assign st_run  = line[1];
    assign st_done = line[2];

endmodule

// File: rtl/flagseq_dp.sv
module flagseq_dp
    import flagseq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  fs_cmd_t          cmd,
    output logic [CNT_W-1:0] cnt,
    output logic             flag_e,
    output logic             flag_f
);

    localparam int TRK_BIT = CNT_W - 2;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.clr) begin
            cnt <= '0;
        end else if (cmd.inc) begin
            cnt <= cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_e <= 1'b0;
        end else if (cmd.e_ld) begin
            flag_e <= cnt[TRK_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_f <= 1'b0;
        end else if (cmd.clr) begin
            flag_f <= 1'b0;
        end else if (cmd.f_set) begin
            flag_f <= 1'b1;
        end
    end

endmodule

// File: rtl/flagseq_ctrl.sv
module flagseq_ctrl
    import flagseq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [CNT_W-1:0] cnt,
    output logic             flag_e,
    output logic             flag_f,
    output logic             st_idle,
    output logic             st_run,
    output logic             st_done
);

    localparam int HI_BIT = CNT_W - 1;
    localparam int LO_BIT = CNT_W - 2;

    fs_state_e state_q;
    fs_state_e state_d;
    fs_cmd_t   cmd;

    flagseq_next u_next (
        .cur    (state_q),
        .start  (start),
        .bit_hi (cnt[HI_BIT]),
        .bit_lo (cnt[LO_BIT]),
        .nxt    (state_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath commands per state
    always_comb begin
        cmd = '0;
        unique case (state_q)
            ST_IDLE:  cmd.clr   = start;
            ST_RUN: begin
                cmd.inc  = 1'b1;
                cmd.e_ld = 1'b1;
            end
            ST_DONE:  cmd.f_set = 1'b1;
            ST_SPARE: cmd       = '0;
        endcase
    end

    flagseq_dp #(.CNT_W(CNT_W)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .cnt    (cnt),
        .flag_e (flag_e),
        .flag_f (flag_f)
    );

    flagseq_dec u_dec (
        .cur     (state_q),
        .st_idle (st_idle),
        .st_run  (st_run),
        .st_done (st_done)
    );

endmodule

// File: rtl/flagseq_chk.sv
module flagseq_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [CNT_W-1:0] cnt,
    input logic             flag_e,
    input logic             flag_f,
    input logic             st_idle,
    input logic             st_run,
    input logic             st_done
);

    localparam int HI_BIT = CNT_W - 1;
    localparam int LO_BIT = CNT_W - 2;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (st_idle && cnt == '0 && !flag_e && !flag_f));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (st_idle && !start) |=> (st_idle && $stable(cnt) && $stable(flag_e) && $stable(flag_f)));

    a_r3_launch: assert property (@(posedge clk) disable iff (rst)
        (st_idle && start) |=> (st_run && cnt == '0 && !flag_f && $stable(flag_e)));

    a_r4_increment: assert property (@(posedge clk) disable iff (rst)
        st_run |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    a_r5_track: assert property (@(posedge clk) disable iff (rst)
        st_run |=> (flag_e == $past(cnt[LO_BIT])));

    a_r6_halt: assert property (@(posedge clk) disable iff (rst)
        (st_run && cnt[HI_BIT] && cnt[LO_BIT]) |=> st_done);

    a_r6_keep_run: assert property (@(posedge clk) disable iff (rst)
        (st_run && !(cnt[HI_BIT] && cnt[LO_BIT])) |=> st_run);

    a_r7_close: assert property (@(posedge clk) disable iff (rst)
        st_done |=> (st_idle && flag_f && $stable(cnt) && $stable(flag_e)));

    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones({st_idle, st_run, st_done}) == 1);

endmodule

bind flagseq_ctrl flagseq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cnt     (cnt),
    .flag_e  (flag_e),
    .flag_f  (flag_f),
    .st_idle (st_idle),
    .st_run  (st_run),
    .st_done (st_done)
);

// File: tb/test_flagseq_ctrl.sv
module test_flagseq_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] cnt;
    logic       flag_e;
    logic       flag_f;
    logic       st_idle;
    logic       st_run;
    logic       st_done;

    int tests  = 0;
    int failed = 0;

    always #10 clk = ~clk;  // 50 MHz

    flagseq_ctrl #(.CNT_W(4)) i_flagseq_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cnt     (cnt),
        .flag_e  (flag_e),
        .flag_f  (flag_f),
        .st_idle (st_idle),
        .st_run  (st_run),
        .st_done (st_done)
    );

    // Expected outputs after one clock edge; st is {done, run, idle}
    typedef struct {
        logic [3:0] cnt;
        logic       e;
        logic       f;
        logic [2:0] st;
        string      tag;
    } exp_t;

    exp_t q[$];

    // Reference model state: 0 idle, 1 run, 2 done
    int         m_st  = 0;
    logic [3:0] m_cnt = '0;
    logic       m_e   = 1'b0;
    logic       m_f   = 1'b0;

    task automatic step(input logic r, input logic s);
        exp_t x;
        @(negedge clk);
        rst   = r;
        start = s;
        if (r) begin
            m_st = 0; m_cnt = '0; m_e = 1'b0; m_f = 1'b0;
            x.tag = "R1";
        end else begin
            case (m_st)
                0: begin
                    if (s) begin
                        m_cnt = '0; m_f = 1'b0; m_st = 1;
                        x.tag = "R3";
                    end else begin
                        x.tag = "R2";
                    end
                end
                1: begin
                    m_e = m_cnt[2];
                    if (m_cnt[3] && m_cnt[2]) begin
                        m_st  = 2;
                        x.tag = s ? "R6 R5 R9" : "R6 R5";
                    end else begin
                        x.tag = s ? "R4 R5 R9" : "R4 R5";
                    end
                    m_cnt = m_cnt + 4'd1;
                end
                default: begin
                    m_f = 1'b1; m_st = 0;
                    x.tag = s ? "R7 R9" : "R7";
                end
            endcase
        end
        x.cnt = m_cnt;
        x.e   = m_e;
        x.f   = m_f;
        x.st  = (m_st == 0) ? 3'b001 : (m_st == 1) ? 3'b010 : 3'b100;
        q.push_back(x);
    endtask

    // Monitor: compare 5 ns after each rising edge
    exp_t mon_x;
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            mon_x = q.pop_front();
            tests++;
            if (cnt !== mon_x.cnt || flag_e !== mon_x.e || flag_f !== mon_x.f ||
                {st_done, st_run, st_idle} !== mon_x.st) begin
                failed++;
                $display("FAIL %s: cnt=%0d e=%b f=%b st=%b, expected cnt=%0d e=%b f=%b st=%b",
                         mon_x.tag, cnt, flag_e, flag_f, {st_done, st_run, st_idle},
                         mon_x.cnt, mon_x.e, mon_x.f, mon_x.st);
            end
            tests++;
            if ($countones({st_done, st_run, st_idle}) != 1) begin
                failed++;
                $display("FAIL R8: indicators=%b, expected exactly one high",
                         {st_done, st_run, st_idle});
            end
        end
    end

    initial begin
        #(20 * 100000);
        failed++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        // R1: reset
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        // R2: idle without start
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        // R3: launch, then counting with start pulses inside run (R9)
        step(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
        // finish the sequence: halt at count 12 (R6), close (R7), idle
        for (int i = 0; i < 7; i++) step(1'b0, 1'b0);
        // relaunch with E and F set; start held across done and into idle
        step(1'b0, 1'b1);
        for (int i = 0; i < 16; i++) step(1'b0, 1'b1);
        for (int i = 0; i < 18; i++) step(1'b0, 1'b0);
        // reset in the middle of a run
        step(1'b0, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0);
        // drain the scoreboard
        @(negedge clk);
        @(negedge clk);
        if (q.size() != 0) begin
            tests++;
            failed++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule